// File: doc/BRIEF.md
# Interpolating Sine Oscillator

A numerically controlled sine source. A phase accumulator adds a frequency tuning word on every enabled clock. The upper accumulator bits select an entry of a compact sine table with a power-of-two number of entries. A plain oscillator would drop the remaining lower bits. Here they serve as a fractional weight, and the output is a straight-line blend between the selected entry and the one after it. With the blend, a small table gives a far cleaner spectrum than simple truncation. The spur floor falls by roughly twelve decibels per address bit, against roughly six.

A runtime mode input selects plain truncation or interpolation for each sample, so both schemes can be compared on the same hardware. The table is computed at elaboration by a constant function, so no external data files are needed. The datapath has three pipeline stages: accumulate, read two neighbouring entries, and blend. Each output sample carries a valid flag.

Top module: `interp_nco`

## Requirements
- R1: On every clock edge with `en` high, the sample phase is the accumulator value held before that edge, and the accumulator then advances by `ftw` modulo 2^ACC_W. A changed `ftw` is used from the next enabled edge onward.
- R2: While `en` is low, the accumulator keeps its value and no sample is produced. While `sine_valid` is low, `sine_out` keeps its last value.
- R3: `sine_valid` is high in the cycle after the third rising edge that follows an enabled edge, and exactly once per enabled edge.
- R4: Synchronous reset sets the phase to zero, drives `sine_valid` low and `sine_out` to 0. The first sample after reset is 0.
- R5: With `mode_interp` = 0, the output is table entry T[a], where a is the top ADDR_W phase bits and T[i] = round(32767·sin(2πi/256)) at the default widths. The error against the ideal sine never exceeds 810 LSB.
- R6: With `mode_interp` = 1, the output is T[a] + floor(((T[a+1] − T[a])·f + 2^23) / 2^24), where f is the 24-bit phase fraction. It stays within 4 LSB of 32767·sin(2π·phase/2^32).
- R7: The entry after index 255 is index 0. At phase 0xFF80_0000 the interpolated output is −402 and the truncated output is −804.
- R8: An interpolated output always lies between the two table entries it blends.
- R9: When the fraction is zero, the interpolated output equals the table entry, within 1 LSB of the ideal sine.
- R10: For tuning words with nonzero fraction bits, truncation mode shows a peak error above 100 LSB over a sweep, while interpolation stays within R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and emit one sample |
| ftw | input | ACC_W | Frequency tuning word (phase step) |
| mode_interp | input | 1 | 1 = linear interpolation, 0 = truncation |
| sine_out | output | SAMP_W | Signed two's-complement sine sample |
| sine_valid | output | 1 | `sine_out` holds a new sample |

## Verification
The bench builds the block at its defaults: a 32-bit accumulator, a 256-entry table of 16-bit signed values and rounding on. That leaves a 24-bit fraction, so sweeps of a few hundred samples reach every table entry, the wrap from index 255 to 0, exact table points and fractions near one. Each sample is compared with a real-valued sine at the phase the bench tracks itself. This makes the different error bounds of the two modes, a tuning word change and an idle gap all visible within a few thousand cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;

   typedef enum logic {
      MODE_TRUNC  = 1'b0,
      MODE_INTERP = 1'b1
   } nco_mode_e;

   localparam real NCO_PI = 3.14159265358979323846;

   // odd power series, argument already folded into [0, pi/2]
   function automatic real series_sin(input real x);
      real term;
      real acc;
      term = x;
      acc  = x;
      for (int k = 1; k < 10; k++) begin
         term = -term * x * x / (real'(2 * k) * real'(2 * k + 1));
         acc  = acc + term;
      end
      return acc;
   endfunction

   // rounded table value for entry idx of an n_ent-entry full-cycle table
   function automatic int sine_code(input int idx, input int n_ent, input int samp_w);
      real ph;
      real sgn;
      real amp;
      real r;
      ph  = 2.0 * NCO_PI * real'(idx) / real'(n_ent);
      sgn = 1.0;
      if (ph >= NCO_PI) begin
         ph  = ph - NCO_PI;
         sgn = -1.0;
      end
      if (ph > NCO_PI / 2.0) ph = NCO_PI - ph;
      amp = real'((1 << (samp_w - 1)) - 1);
      r   = amp * sgn * series_sin(ph);
      if (r >= 0.0) return $rtoi(r + 0.5);
      else          return -$rtoi(0.5 - r);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
   import nco_pkg::*;
#(
   parameter  int ACC_W  = 32,
   parameter  int ADDR_W = 8,
   localparam int FRAC_W = ACC_W - ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [ACC_W-1:0]  ftw,
   input  nco_mode_e         mode,
   output logic [ACC_W-1:0]  acc_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [FRAC_W-1:0] frac_q,
   output nco_mode_e         mode_q,
   output logic              vld_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         addr_q <= '0;
         frac_q <= '0;
         mode_q <= MODE_TRUNC;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= en;
         if (en) begin
            {addr_q, frac_q} <= acc_q;
            mode_q           <= mode;
            acc_q            <= acc_q + ftw;
         end
      end
   end

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom
   import nco_pkg::*;
#(
   parameter  int ADDR_W = 8,
   parameter  int FRAC_W = 24,
   parameter  int SAMP_W = 16,
   localparam int N_ENT  = 1 << ADDR_W
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [FRAC_W-1:0]        frac,
   input  nco_mode_e                mode,
   input  logic                     vld,
   output logic signed [SAMP_W-1:0] t0_q,
   output logic signed [SAMP_W-1:0] t1_q,
   output logic [FRAC_W-1:0]        frac_q,
   output nco_mode_e                mode_q,
   output logic                     vld_q
);

   logic signed [SAMP_W-1:0] rom [N_ENT];
   logic [ADDR_W-1:0]        addr_nxt;

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      localparam int CODE = sine_code(g, N_ENT, SAMP_W);
      assign rom[g] = SAMP_W'(CODE);
   end

   // natural wrap: entry after the last is entry 0
   assign addr_nxt = addr + ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         t0_q   <= '0;
         t1_q   <= '0;
         frac_q <= '0;
         mode_q <= MODE_TRUNC;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= vld;
         if (vld) begin
            t0_q   <= rom[addr];
            t1_q   <= rom[addr_nxt];
            frac_q <= frac;
            mode_q <= mode;
         end
      end
   end

endmodule

// File: rtl/nco_interp.sv
module nco_interp
   import nco_pkg::*;
#(
   parameter  int FRAC_W = 24,
   parameter  int SAMP_W = 16,
   parameter  bit ROUND  = 1'b1,
   localparam int PROD_W = SAMP_W + FRAC_W + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [SAMP_W-1:0] t0,
   input  logic signed [SAMP_W-1:0] t1,
   input  logic [FRAC_W-1:0]        frac,
   input  nco_mode_e                mode,
   input  logic                     vld,
   output logic signed [SAMP_W-1:0] y_q,
   output logic                     vld_q
);

   localparam logic signed [PROD_W-1:0] Y_MAX = PROD_W'((1 << (SAMP_W - 1)) - 1);
   localparam logic signed [PROD_W-1:0] Y_MIN = -PROD_W'(1 << (SAMP_W - 1));

   logic signed [PROD_W-1:0] diff;
   logic signed [PROD_W-1:0] weight;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] bias;
   logic signed [PROD_W-1:0] corr;
   logic signed [PROD_W-1:0] sum;
   logic signed [SAMP_W-1:0] y_d;

   if (ROUND) begin : g_round
      assign bias = PROD_W'(1) <<< (FRAC_W - 1);
   end else begin : g_floor
      assign bias = '0;
   end

   always_comb begin
      diff   = PROD_W'(t1) - PROD_W'(t0);
      weight = $signed({{(PROD_W - FRAC_W){1'b0}}, frac});
      prod   = diff * weight;
      corr   = (prod + bias) >>> FRAC_W;
      sum    = (mode == MODE_INTERP) ? PROD_W'(t0) + corr : PROD_W'(t0);
      if (sum > Y_MAX)      y_d = Y_MAX[SAMP_W-1:0];
      else if (sum < Y_MIN) y_d = Y_MIN[SAMP_W-1:0];
      else                  y_d = sum[SAMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y_q   <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= vld;
         if (vld) y_q <= y_d;
      end
   end

endmodule

// File: rtl/interp_nco.sv
module interp_nco
   import nco_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 8,
   parameter int SAMP_W = 16,
   parameter bit ROUND  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic [ACC_W-1:0]         ftw,
   input  logic                     mode_interp,
   output logic signed [SAMP_W-1:0] sine_out,
   output logic                     sine_valid
);

   localparam int FRAC_W = ACC_W - ADDR_W;

   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
      $error("interp_nco: ADDR_W must lie in 2..12");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("interp_nco: ACC_W must exceed ADDR_W");
   end
   if (SAMP_W < 4 || SAMP_W > 24) begin : g_bad_samp
      $error("interp_nco: SAMP_W must lie in 4..24");
   end

   logic [ACC_W-1:0]         acc_q;
   logic [ADDR_W-1:0]        addr_q;
   logic [FRAC_W-1:0]        frac_a;
   nco_mode_e                mode_a;
   logic                     vld_a;
   logic signed [SAMP_W-1:0] t0_q;
   logic signed [SAMP_W-1:0] t1_q;
   logic [FRAC_W-1:0]        frac_r;
   nco_mode_e                rmode_q;
   logic                     rvld_q;

   nco_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .ftw    (ftw),
      .mode   (nco_mode_e'(mode_interp)),
      .acc_q  (acc_q),
      .addr_q (addr_q),
      .frac_q (frac_a),
      .mode_q (mode_a),
      .vld_q  (vld_a)
   );

   nco_sine_rom #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .SAMP_W(SAMP_W)) u_rom (
      .clk    (clk),
      .rst    (rst),
      .addr   (addr_q),
      .frac   (frac_a),
      .mode   (mode_a),
      .vld    (vld_a),
      .t0_q   (t0_q),
      .t1_q   (t1_q),
      .frac_q (frac_r),
      .mode_q (rmode_q),
      .vld_q  (rvld_q)
   );

   nco_interp #(.FRAC_W(FRAC_W), .SAMP_W(SAMP_W), .ROUND(ROUND)) u_int (
      .clk   (clk),
      .rst   (rst),
      .t0    (t0_q),
      .t1    (t1_q),
      .frac  (frac_r),
      .mode  (rmode_q),
      .vld   (rvld_q),
      .y_q   (sine_out),
      .vld_q (sine_valid)
   );

endmodule

// File: rtl/interp_nco_chk.sv
module interp_nco_chk #(
   parameter int ACC_W  = 32,
   parameter int SAMP_W = 16
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     en,
   input logic [ACC_W-1:0]         acc,
   input logic signed [SAMP_W-1:0] t0,
   input logic signed [SAMP_W-1:0] t1,
   input logic                     rmode,
   input logic                     rvld,
   input logic signed [SAMP_W-1:0] sine_out,
   input logic                     sine_valid
);

   logic [2:0]               en_hist;
   logic signed [SAMP_W-1:0] t0_d;
   logic signed [SAMP_W-1:0] t1_d;
   logic                     mode_d;
   logic                     vld_d;
   logic signed [SAMP_W-1:0] lo;
   logic signed [SAMP_W-1:0] hi;

   always_ff @(posedge clk) begin
      if (rst) begin
         en_hist <= '0;
         t0_d    <= '0;
         t1_d    <= '0;
         mode_d  <= 1'b0;
         vld_d   <= 1'b0;
      end else begin
         en_hist <= {en_hist[1:0], en};
         t0_d    <= t0;
         t1_d    <= t1;
         mode_d  <= rmode;
         vld_d   <= rvld;
      end
   end

   assign lo = (t0_d < t1_d) ? t0_d : t1_d;
   assign hi = (t0_d < t1_d) ? t1_d : t0_d;

   AST_IDLE_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc)); // R2
   AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sine_valid |-> $stable(sine_out)); // R2
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
      sine_valid == en_hist[2]); // R3
   AST_TRUNC_PASS: assert property (@(posedge clk) disable iff (rst)
      (vld_d && !mode_d) |-> (sine_out == t0_d)); // R5
   AST_INTERP_BRACKET: assert property (@(posedge clk) disable iff (rst)
      (vld_d && mode_d) |-> ((sine_out >= lo) && (sine_out <= hi))); // R8

endmodule

bind interp_nco interp_nco_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .en         (en),
   .acc        (acc_q),
   .t0         (t0_q),
   .t1         (t1_q),
   .rmode      (rmode_q),
   .rvld       (rvld_q),
   .sine_out   (sine_out),
   .sine_valid (sine_valid)
);

// File: tb/interp_nco_tb.sv
module interp_nco_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   // sweep vectors: tuning word, mode, sample count, error tolerance, minimum peak error
   localparam logic [31:0] VEC_FTW  [NV] = '{32'h0100_0000, 32'h0100_0000, 32'h0123_4567, 32'h0123_4567,
                                             32'h3A5C_9D17, 32'h0009_ABCD, 32'h0009_ABCD, 32'hFFF0_1234};
   localparam bit          VEC_MODE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
   localparam int          VEC_N    [NV] = '{256, 256, 600, 600, 500, 600, 600, 400};
   localparam int          VEC_TOL  [NV] = '{1, 1, 4, 810, 4, 810, 4, 4};
   localparam int          VEC_MIN  [NV] = '{0, 0, 0, 100, 0, 100, 0, 0};

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en = 1'b0;
   logic [31:0]        ftw = '0;
   logic               mode_interp = 1'b0;
   logic signed [15:0] sine_out;
   logic               sine_valid;

   int          n_checks = 0;
   int          n_fails = 0;
   logic [31:0] acc_model;
   logic [31:0] q_ph [0:4095];
   logic        q_md [0:4095];
   int          q_wr, q_rd;
   logic signed [15:0] last_out;
   real         max_err;
   real         tol_i, tol_t;

   interp_nco u_dut (
      .clk(clk), .rst(rst), .en(en), .ftw(ftw), .mode_interp(mode_interp),
      .sine_out(sine_out), .sine_valid(sine_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic real ideal(input logic [31:0] ph);
      return 32767.0 * $sin(6.283185307179586 * real'(longint'({32'd0, ph})) / 4294967296.0);
   endfunction

   task automatic check_eq(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic observe();
      real err;
      real tol;
      if (sine_valid) begin
         n_checks++;
         if (q_rd >= q_wr) begin
            n_fails++;
            $display("FAIL R3: actual unexpected sample %0d expected no sample", sine_out);
         end else begin
            err = real'(int'(sine_out)) - ideal(q_ph[q_rd]);
            if (err < 0.0) err = -err;
            tol = q_md[q_rd] ? tol_i : tol_t;
            if (err > max_err) max_err = err;
            if (err > tol) begin
               n_fails++;
               $display("FAIL %s: actual %0d expected %0.2f (phase %h)",
                        q_md[q_rd] ? "R6" : "R5", sine_out, ideal(q_ph[q_rd]), q_ph[q_rd]);
            end
            q_rd++;
         end
      end else begin
         check_eq("R2", int'(sine_out), int'(last_out));
      end
      last_out = sine_out;
   endtask

   // one cycle: observe the previous edge, then drive the next one (R1 model)
   task automatic step(input logic e, input logic [31:0] f, input logic m);
      @(negedge clk);
      observe();
      en = e;
      ftw = f;
      mode_interp = m;
      if (e) begin
         q_ph[q_wr] = acc_model;
         q_md[q_wr] = m;
         q_wr++;
         acc_model = acc_model + f;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en = 1'b0;
      repeat (3) @(negedge clk);
      check_eq("R4 valid", int'(sine_valid), 0);
      check_eq("R4 out", int'(sine_out), 0);
      rst = 1'b0;
      acc_model = '0;
      q_wr = 0;
      q_rd = 0;
      last_out = '0;
      max_err = 0.0;
   endtask

   task automatic drain();
      repeat (5) step(1'b0, ftw, mode_interp);
      check_eq("R3 all samples", q_rd, q_wr);
   endtask

   task automatic wrap_probe(input logic m, input int exp);
      do_reset();
      @(negedge clk);
      en = 1'b1; ftw = 32'hFF80_0000; mode_interp = m;
      @(negedge clk);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      check_eq("R4 first sample", int'(sine_out), 0);
      @(negedge clk);
      check_eq("R7 wrap sample valid", int'(sine_valid), 1);
      check_eq(m ? "R7 interp wrap" : "R7 R5 trunc wrap", int'(sine_out), exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      tol_i = 4.0;
      tol_t = 810.0;

      // vector walk: R5, R6, R9, R10, R7 (negative step crosses the wrap)
      for (int v = 0; v < NV; v++) begin
         do_reset();
         tol_i = real'(VEC_TOL[v]);
         tol_t = real'(VEC_TOL[v]);
         for (int k = 0; k < VEC_N[v]; k++) step(1'b1, VEC_FTW[v], VEC_MODE[v]);
         drain();
         if (VEC_MIN[v] > 0) begin
            n_checks++;
            if (max_err <= real'(VEC_MIN[v])) begin
               n_fails++;
               $display("FAIL R10: actual peak %0.2f expected above %0d", max_err, VEC_MIN[v]);
            end
         end
      end

      // R3 latency and R4 first sample
      do_reset();
      @(negedge clk);
      en = 1'b1; ftw = 32'h1234_5678; mode_interp = 1'b1;
      @(negedge clk);
      en = 1'b0;
      check_eq("R3 edge1", int'(sine_valid), 0);
      @(negedge clk);
      check_eq("R3 edge2", int'(sine_valid), 0);
      @(negedge clk);
      check_eq("R3 edge3", int'(sine_valid), 1);
      check_eq("R4 first sample zero", int'(sine_out), 0);
      @(negedge clk);
      check_eq("R3 single pulse", int'(sine_valid), 0);
      check_eq("R2 output held", int'(sine_out), 0);

      // R7 exact wrap values, both modes
      wrap_probe(1'b1, -402);
      wrap_probe(1'b0, -804);

      // R1 tuning change, R2 idle gap, mode switching mid-stream
      do_reset();
      tol_i = 4.0;
      tol_t = 810.0;
      for (int k = 0; k < 6; k++) step(1'b1, 32'h0234_5678, 1'b1);
      for (int k = 0; k < 5; k++) step(1'b0, 32'h7777_0000, 1'b1);
      for (int k = 0; k < 6; k++) step(1'b1, 32'h0A1B_2C3D, 1'b0);
      for (int k = 0; k < 6; k++) step(1'b1, 32'h0A1B_2C3D, 1'b1);
      for (int k = 0; k < 3; k++) step(1'b1, 32'h0100_0000, k[0]);
      drain();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule